// File: doc/BRIEF.md
# Cascadable Up/Down Binary Counter Stage

This block is a synchronous binary counter, four bits wide by default. It can count up or down and can be preset in parallel. All state bits change on the same rising clock edge. An active-low load request copies the data input into the counter on the next edge, whatever the count enables are doing. With no load, the counter steps by one only when both of its active-low enables are low. One enable gates the local stage only. The other also gates the terminal-count output. The step direction comes from a single select input.

The terminal-count output is active low and purely combinational. It falls when the carry enable is low and the count sits at the end of its range for the selected direction: all ones going up, all zeros going down. To make a wider counter, share the clock, load, direction and local enable across the stages, and feed each stage's terminal count into the carry enable of the next stage up. A synchronous active-high reset clears the count and overrides every other control.

Top module: `updn_counter`

## Requirements
- R1: When `rst` is high at a rising edge, the count becomes 0 after that edge, even if `load_n` is low.
- R2: When `rst` is low and `load_n` is low at a rising edge, the count takes the value of `din` after that edge, whatever the levels of `en_p_n` and `en_c_n`.
- R3: When `rst` and `load_n` are both inactive and either `en_p_n` or `en_c_n` is high, the count keeps its value across the edge.
- R4: With no reset or load, both enables low and `up` = 1, the count increments by one, and the all-ones value wraps to 0.
- R5: With no reset or load, both enables low and `up` = 0, the count decrements by one, and 0 wraps to all ones.
- R6: `tc_n` is low in the same cycle, with no register in the path, exactly when `en_c_n` is low and the count is either all ones with `up` = 1 or 0 with `up` = 0. At all other times `tc_n` is high.
- R7: Any value from 0 to 2^WIDTH-1 can be preset through `din`.
- R8: Two stages chained, with the low stage's `tc_n` driving the high stage's `en_c_n` and all other controls shared, behave as one 2·WIDTH-bit counter. They follow R2 to R5, and the high stage's `tc_n` marks the terminal value of the combined count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous clear, active high, highest priority |
| load_n | input | 1 | Parallel load request, active low |
| up | input | 1 | Direction: 1 counts up, 0 counts down |
| en_p_n | input | 1 | Local count enable, active low |
| en_c_n | input | 1 | Carry count enable, active low; also gates `tc_n` |
| din | input | WIDTH | Preset value |
| cnt | output | WIDTH | Current count |
| tc_n | output | 1 | Terminal count, active low, combinational |

## Verification
The assertions assume that every control input is a defined level at each rising edge. They also assume that `din` is valid whenever a load is requested. The properties that look one cycle ahead are not evaluated while reset is high. The bench changes inputs only on falling edges, so every sampled value is stable. It releases reset only after the first edge has cleared the count. Stimulus covers every preset value, every enable pair that should hold, and full sweeps through both wraps of the chained count.

// File: rtl/updn_counter_pkg.sv
package updn_counter_pkg;

   // Operation selected for the coming clock edge, in priority order
   typedef enum logic [1:0] {
      OP_CLEAR = 2'd0,
      OP_LOAD  = 2'd1,
      OP_STEP  = 2'd2,
      OP_HOLD  = 2'd3
   } ctr_op_e;

   // Next-state implementation variants
   localparam int STEP_ARITH  = 0;
   localparam int STEP_TOGGLE = 1;

endpackage

// File: rtl/ctr_mode_sel.sv
module ctr_mode_sel
   import updn_counter_pkg::*;
(
   input  logic    rst,
   input  logic    load_n,
   input  logic    en_p_n,
   input  logic    en_c_n,
   output ctr_op_e op
);

   always_comb begin
      if (rst)
         op = OP_CLEAR;
      else if (!load_n)
         op = OP_LOAD;
      else if (!en_p_n && !en_c_n)
         op = OP_STEP;
      else
         op = OP_HOLD;
   end

endmodule

// File: rtl/ctr_step.sv
module ctr_step
   import updn_counter_pkg::*;
#(
   parameter int WIDTH     = 4,
   parameter int STEP_IMPL = STEP_TOGGLE
) (
   input  logic [WIDTH-1:0] cur,
   input  logic             up,
   output logic [WIDTH-1:0] nxt
);

   generate
      if (STEP_IMPL == STEP_ARITH) begin : g_arith
         always_comb begin
            if (up)
               nxt = cur + WIDTH'(1);
            else
               nxt = cur - WIDTH'(1);
         end
      end else begin : g_toggle
         // bit i flips when every lower bit is at the extreme for the direction
         logic [WIDTH-1:0] tog;
         assign tog[0] = 1'b1;
         for (genvar i = 1; i < WIDTH; i++) begin : g_chain
            assign tog[i] = tog[i-1] & (up ? cur[i-1] : ~cur[i-1]);
         end
         assign nxt = cur ^ tog;
      end
   endgenerate

endmodule

// File: rtl/ctr_tc_decode.sv
module ctr_tc_decode #(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] cur,
   input  logic             up,
   input  logic             en_c_n,
   output logic             tc_n
);

   logic at_top;
   logic at_bottom;

   assign at_top    = &cur;
   assign at_bottom = ~|cur;
   assign tc_n      = ~(~en_c_n & (up ? at_top : at_bottom));

endmodule

// File: rtl/updn_counter.sv
module updn_counter
   import updn_counter_pkg::*;
#(
   parameter int WIDTH     = 4,
   parameter int STEP_IMPL = STEP_TOGGLE
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load_n,
   input  logic             up,
   input  logic             en_p_n,
   input  logic             en_c_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] cnt,
   output logic             tc_n
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("updn_counter: WIDTH must be at least 1");
      end
      if (STEP_IMPL != STEP_ARITH && STEP_IMPL != STEP_TOGGLE) begin : g_bad_impl
         $error("updn_counter: unknown STEP_IMPL");
      end
   endgenerate

   ctr_op_e          op;
   logic [WIDTH-1:0] stepped;
   logic [WIDTH-1:0] q;

   ctr_mode_sel u_mode (
      .rst    (rst),
      .load_n (load_n),
      .en_p_n (en_p_n),
      .en_c_n (en_c_n),
      .op     (op)
   );

   ctr_step #(
      .WIDTH     (WIDTH),
      .STEP_IMPL (STEP_IMPL)
   ) u_step (
      .cur (q),
      .up  (up),
      .nxt (stepped)
   );

   ctr_tc_decode #(
      .WIDTH (WIDTH)
   ) u_tc (
      .cur    (q),
      .up     (up),
      .en_c_n (en_c_n),
      .tc_n   (tc_n)
   );

   always_ff @(posedge clk) begin
      unique case (op)
         OP_CLEAR: q <= '0;
         OP_LOAD:  q <= din;
         OP_STEP:  q <= stepped;
         default:  q <= q;
      endcase
   end

   assign cnt = q;

endmodule

// File: rtl/updn_counter_chk.sv
module updn_counter_chk #(
   parameter int WIDTH = 4
) (
   input logic             clk,
   input logic             rst,
   input logic             load_n,
   input logic             up,
   input logic             en_p_n,
   input logic             en_c_n,
   input logic [WIDTH-1:0] din,
   input logic [WIDTH-1:0] cnt,
   input logic             tc_n
);

   localparam logic [WIDTH-1:0] TOP = '1;

   assert_clear_R1: assert property (@(posedge clk)
      rst |=> cnt == '0);

   assert_load_R2: assert property (@(posedge clk) disable iff (rst)
      !load_n |=> cnt == $past(din));

   assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
      (load_n && (en_p_n || en_c_n)) |=> $stable(cnt));

   assert_inc_R4: assert property (@(posedge clk) disable iff (rst)
      (load_n && !en_p_n && !en_c_n && up) |=> cnt == WIDTH'($past(cnt) + 1'b1));

   assert_dec_R5: assert property (@(posedge clk) disable iff (rst)
      (load_n && !en_p_n && !en_c_n && !up) |=> cnt == WIDTH'($past(cnt) - 1'b1));

   assert_tc_gate_R6: assert property (@(posedge clk) disable iff (rst)
      en_c_n |-> tc_n);

   assert_tc_range_R6: assert property (@(posedge clk) disable iff (rst)
      !tc_n |-> (up ? cnt == TOP : cnt == '0));

endmodule

bind updn_counter updn_counter_chk #(.WIDTH(WIDTH)) u_chk (
   .clk    (clk),
   .rst    (rst),
   .load_n (load_n),
   .up     (up),
   .en_p_n (en_p_n),
   .en_c_n (en_c_n),
   .din    (din),
   .cnt    (cnt),
   .tc_n   (tc_n)
);

// File: tb/test_updn_counter.sv
module test_updn_counter;

   localparam int CLK_PERIOD = 10;
   localparam int W = 4;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         load_n = 1'b0;
   logic         up = 1'b1;
   logic         en_p_n = 1'b0;
   logic         en_c_n = 1'b0;
   logic [7:0]   din = 8'hA5;
   logic [W-1:0] cnt_lo, cnt_hi;
   logic         tc_lo_n, tc_hi_n;

   int checks = 0;
   int fails  = 0;
   int model  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   updn_counter #(.WIDTH(W)) i_updn_counter (
      .clk(clk), .rst(rst), .load_n(load_n), .up(up),
      .en_p_n(en_p_n), .en_c_n(en_c_n), .din(din[3:0]),
      .cnt(cnt_lo), .tc_n(tc_lo_n));

   updn_counter #(.WIDTH(W)) i_updn_counter_hi (
      .clk(clk), .rst(rst), .load_n(load_n), .up(up),
      .en_p_n(en_p_n), .en_c_n(tc_lo_n), .din(din[7:4]),
      .cnt(cnt_hi), .tc_n(tc_hi_n));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // terminal-count expectations, checked with the inputs of the current cycle
   task automatic chk_tc(input string req);
      int lo, hi;
      bit lo_t, hi_t;
      lo = model % 16;
      hi = model / 16;
      lo_t = !en_c_n && (up ? lo == 15 : lo == 0);
      hi_t = lo_t && (up ? hi == 15 : hi == 0);
      #1;
      chk({req, " R6 tc_lo"}, int'(tc_lo_n), int'(!lo_t));
      chk({req, " R8 tc_hi"}, int'(tc_hi_n), int'(!hi_t));
   endtask

   // one clock with the currently driven inputs; expected value computed first
   task automatic step(input string req);
      if (rst) model = 0;
      else if (!load_n) model = int'(din);
      else if (!en_p_n && !en_c_n) model = up ? (model + 1) % 256 : (model + 255) % 256;
      @(posedge clk);
      @(negedge clk);
      chk(req, int'({cnt_hi, cnt_lo}), model);
   endtask

   initial begin
      // R1: reset wins over a pending load
      @(negedge clk);
      step("R1 reset over load");
      rst = 1'b0;
      load_n = 1'b1;
      chk_tc("R1 after reset");

      // R2/R7: every preset value, enables inactive and then active
      for (int v = 0; v < 16; v++) begin
         din = {4'(15 - v), 4'(v)};
         load_n = 1'b0;
         en_p_n = 1'b1; en_c_n = 1'b1;
         step("R2 R7 load, enables high");
         din = {4'(v), 4'(15 - v)};
         en_p_n = 1'b0; en_c_n = 1'b0; up = v[0];
         step("R2 R7 load, enables low");
      end
      load_n = 1'b1;

      // R3: each enable pair that must hold, both directions, at terminal values
      for (int d = 0; d < 2; d++) begin
         for (int e = 1; e < 4; e++) begin
            din = d[0] ? 8'hFF : 8'h00;
            load_n = 1'b0;
            step("R3 preset");
            load_n = 1'b1;
            up = d[0];
            en_p_n = e[0]; en_c_n = e[1];
            chk_tc("R3 R6 gated");
            step("R3 hold");
            step("R3 hold again");
         end
      end

      // R4/R8: upward sweep through the 8-bit wrap
      din = 8'hF0; load_n = 1'b0; step("R2 preset for up sweep");
      load_n = 1'b1; en_p_n = 1'b0; en_c_n = 1'b0; up = 1'b1;
      for (int i = 0; i < 300; i++) begin
         chk_tc("R4 sweep");
         step("R4 R8 count up");
      end

      // R5/R8: downward sweep through the 8-bit wrap
      up = 1'b0;
      for (int i = 0; i < 300; i++) begin
         chk_tc("R5 sweep");
         step("R5 R8 count down");
      end

      // mixed: direction and enables changing every cycle
      for (int i = 0; i < 128; i++) begin
         up = i[2];
         en_p_n = (i % 7) == 3;
         en_c_n = (i % 5) == 4;
         chk_tc("R3 R4 R5 mixed");
         step("R3 R4 R5 R8 mixed");
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      done = 1'b1;
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule